// File: doc/BRIEF.md
# Hashed page table walker

This block is a sequential walker that resolves a segmented virtual page to a physical page by scanning a hashed translation table kept in ordinary memory. A request supplies the virtual segment identifier (VSID), the effective address, a store flag, and the base and size mask of the table. The walker hashes the segment identifier with the page index and reads candidate entries from the group the hash selects. If nothing in that group matches, it searches a second group chosen by the complemented hash.

When an entry matches, the walker sets the entry's referenced bit and, for stores, its changed bit. Each of these updates is a single byte write. It then reports the physical address and whether a write through this translation may be granted. Access-right decisions belong to a separate checker.

Memory is reached through a word read port and a byte write port. Each port holds its request until the memory answers with ready. A returned read word is valid in the cycle its ready is high.

Top module: `hpt_walker`

## Requirements
- R1: The page index is effective-address bits 27:12 and the hash is the VSID XOR the zero-extended page index. The first read of a walk is word 0 of entry 0 at byte address base + ((hash << 6) AND mask). Every read address is word aligned.
- R2: An entry matches only when all of the following hold: word 0 bit 31 (valid) is 1; word 0 bit 6 (H) equals the pass (0 on the primary pass, 1 on the secondary pass); bits 30:7 equal the VSID; and bits 5:0 equal page-index bits 15:10.
- R3: Entries are 8 bytes and a group holds 8 of them. They are scanned from index 0 upward. Word 0 (offset 0) of an entry is read before its word 1 (offset 4), and word 1 is read only for a matching entry. The read and write ports are never active together.
- R4: If no primary entry matches, the walk repeats over the group at base + ((NOT hash << 6) AND mask), with H required to be 1.
- R5: If neither group matches, done rises with found low and wr_ok low, after exactly 16 word-0 reads and no writes.
- R6: If word 1 bit 8 (R) is clear, the walker writes entry byte offset 6 with the old bits 15:8 of word 1 ORed with 0x01. If R is set, it does not write that byte.
- R7: If word 1 bit 7 (C) is clear and the access is a store, the walker writes entry byte offset 7 with the old bits 7:0 ORed with 0x80, after any R write. It makes no such write for loads or when C is already set.
- R8: On a hit, wr_ok is 1 when C was already set or the access is a store. For a load with C clear, wr_ok is 0.
- R9: On a hit, paddr is word 1 bits 31:12 concatenated with effective-address bits 11:0.
- R10: done is a single-cycle pulse. A start pulse that arrives while a walk is in progress has no effect on that walk's result.
- R11: A read or write request keeps its address and data unchanged until the cycle in which its ready is high.
- R12: After reset, done, found and wr_ok are 0 and neither memory port is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| vsid | input | 24 | Virtual segment identifier |
| ea | input | 32 | Effective address |
| store | input | 1 | Access is a store |
| tbl_base | input | 32 | Byte address of the table |
| tbl_mask | input | 32 | Mask applied to the group byte offset |
| mem_rd_valid | output | 1 | Word read request |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rd_ready | input | 1 | Read accepted; data valid this cycle |
| mem_rd_data | input | 32 | Read word |
| mem_wr_valid | output | 1 | Byte write request |
| mem_wr_addr | output | 32 | Byte address to write |
| mem_wr_data | output | 8 | Byte value to write |
| mem_wr_ready | input | 1 | Write accepted |
| done | output | 1 | Walk finished (one-cycle pulse) |
| found | output | 1 | A matching entry was found |
| paddr | output | 32 | Physical address |
| wr_ok | output | 1 | Writes may be granted through this translation |

## Verification
The hardest cases to reach from the ports are the secondary pass and the decoy entries that must be skipped. These include an entry whose tag matches but whose H bit does not fit the pass, and an entry whose tag matches but whose valid bit is clear. The bench builds the table image itself for each lookup. It sweeps every slot in both groups against all four combinations of R and C and both access kinds, and places both decoy kinds ahead of the real entry. Memory ready is throttled in a repeating pattern so that every request is seen waiting. A start pulse is also injected in the middle of a walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_W0, S_W1, S_SETR, S_SETC, S_FIN
  } walk_st_t;

  // word 0 layout
  localparam int V_BIT = 31;
  // word 1 layout
  localparam int R_BIT = 8;
  localparam int C_BIT = 7;
  localparam logic [7:0] R_SET = 8'h01;
  localparam logic [7:0] C_SET = 8'h80;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int AW      = 32,
  parameter int VSID_W  = 24,
  parameter int PIDX_W  = 16,
  parameter int GRP_SH  = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     mask,
  output logic [AW-1:0]     grp_pri,
  output logic [AW-1:0]     grp_sec
);
  logic [VSID_W-1:0] hash;
  logic [AW-1:0]     hash_w;

  always_comb begin
    hash    = vsid ^ VSID_W'(pidx);
    hash_w  = AW'(hash);
    grp_pri = base + ((hash_w << GRP_SH) & mask);
    grp_sec = base + ((~hash_w << GRP_SH) & mask);
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int WORD_W = 32,
  parameter int VSID_W = 24,
  parameter int API_W  = 6
) (
  input  logic [WORD_W-1:0] w0,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              sec,
  output logic              hit
);
  localparam int H_BIT   = API_W;
  localparam int VS_LO   = API_W + 1;
  localparam int VS_HI   = VS_LO + VSID_W - 1;

  always_comb begin
    hit = w0[WORD_W-1] && (w0[H_BIT] == sec) &&
          (w0[VS_HI:VS_LO] == vsid) && (w0[API_W-1:0] == api);
  end

  initial begin
    assert (VS_HI == WORD_W - 2)
      else $error("word 0 field layout does not fill the word");
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int AW          = 32,
  parameter int VSID_W      = 24,
  parameter int PAGE_SH     = 12,
  parameter int SEG_SH      = 28,
  parameter int API_SH      = 10,
  parameter int GRP_ENTRIES = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VSID_W-1:0] vsid,
  input  logic [AW-1:0]     ea,
  input  logic              store,
  input  logic [AW-1:0]     tbl_base,
  input  logic [AW-1:0]     tbl_mask,
  output logic              mem_rd_valid,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [AW-1:0]     mem_rd_data,
  output logic              mem_wr_valid,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  input  logic              mem_wr_ready,
  output logic              done,
  output logic              found,
  output logic [AW-1:0]     paddr,
  output logic              wr_ok
);
  import hpt_pkg::*;

  localparam int PIDX_W   = SEG_SH - PAGE_SH;
  localparam int API_W    = PIDX_W - API_SH;
  localparam int IDX_W    = $clog2(GRP_ENTRIES);
  localparam int ENT_SH   = $clog2(ENTRY_BYTES);
  localparam int GRP_SH   = $clog2(GRP_ENTRIES * ENTRY_BYTES);
  localparam int W1_OFS   = ENTRY_BYTES / 2;
  localparam int R_OFS    = ENTRY_BYTES - 2;
  localparam int C_OFS    = ENTRY_BYTES - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_ENTRIES - 1);

  walk_st_t          st;
  logic [IDX_W-1:0]  idx;
  logic              pass;
  logic [VSID_W-1:0] vsid_q;
  logic [AW-1:0]     ea_q, base_q, mask_q, w1_q;
  logic              st_q;
  logic              done_q, found_q, wr_ok_q;
  logic [AW-1:0]     paddr_q;

  logic [PIDX_W-1:0] pidx;
  logic [AW-1:0]     grp_pri, grp_sec, grp, ent;
  logic              hit;
  logic              c_needed;

  assign pidx = ea_q[SEG_SH-1:PAGE_SH];

  hpt_hash #(.AW(AW), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .GRP_SH(GRP_SH)) u_hash (
    .vsid(vsid_q), .pidx(pidx), .base(base_q), .mask(mask_q),
    .grp_pri(grp_pri), .grp_sec(grp_sec)
  );

  hpt_match #(.WORD_W(AW), .VSID_W(VSID_W), .API_W(API_W)) u_match (
    .w0(mem_rd_data), .vsid(vsid_q), .api(pidx[PIDX_W-1:API_SH]),
    .sec(pass), .hit(hit)
  );

  always_comb begin
    grp          = pass ? grp_sec : grp_pri;
    ent          = grp + (AW'(idx) << ENT_SH);
    mem_rd_valid = (st == S_W0) || (st == S_W1);
    mem_rd_addr  = ent + ((st == S_W1) ? AW'(W1_OFS) : '0);
    mem_wr_valid = (st == S_SETR) || (st == S_SETC);
    mem_wr_addr  = ent + ((st == S_SETR) ? AW'(R_OFS) : AW'(C_OFS));
    mem_wr_data  = (st == S_SETR) ? (w1_q[15:8] | R_SET) : (w1_q[7:0] | C_SET);
    c_needed     = st_q && !w1_q[C_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      idx     <= '0;
      pass    <= 1'b0;
      vsid_q  <= '0;
      ea_q    <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      st_q    <= 1'b0;
      w1_q    <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      wr_ok_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          vsid_q <= vsid;
          ea_q   <= ea;
          base_q <= tbl_base;
          mask_q <= tbl_mask;
          st_q   <= store;
          idx    <= '0;
          pass   <= 1'b0;
          st     <= S_W0;
        end
        S_W0: if (mem_rd_ready) begin
          if (hit) begin
            st <= S_W1;
          end else if (idx == LAST_IDX) begin
            idx <= '0;
            if (!pass) begin
              pass <= 1'b1;
            end else begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              found_q <= 1'b0;
              wr_ok_q <= 1'b0;
              paddr_q <= '0;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_W1: if (mem_rd_ready) begin
          w1_q <= mem_rd_data;
          if (!mem_rd_data[R_BIT])                     st <= S_SETR;
          else if (st_q && !mem_rd_data[C_BIT])        st <= S_SETC;
          else                                         st <= S_FIN;
        end
        S_SETR: if (mem_wr_ready) st <= c_needed ? S_SETC : S_FIN;
        S_SETC: if (mem_wr_ready) st <= S_FIN;
        S_FIN: begin
          st      <= S_IDLE;
          done_q  <= 1'b1;
          found_q <= 1'b1;
          wr_ok_q <= w1_q[C_BIT] || st_q;
          paddr_q <= {w1_q[AW-1:PAGE_SH], ea_q[PAGE_SH-1:0]};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done  = done_q;
  assign found = found_q;
  assign wr_ok = wr_ok_q;
  assign paddr = paddr_q;

  // assertions
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> $stable(vsid_q) && $stable(ea_q) && $stable(st_q));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
  assert_port_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_valid && mem_wr_valid));
  assert_rd_align_R1: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));
  assert_rbyte_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && (mem_wr_addr[ENT_SH-1:0] == ENT_SH'(R_OFS)) |-> mem_wr_data[0]);
  assert_cbyte_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && (mem_wr_addr[ENT_SH-1:0] == ENT_SH'(C_OFS)) |-> mem_wr_data[7] && st_q);
  assert_miss_R5: assert property (@(posedge clk) disable iff (rst)
    done && !found |-> !wr_ok);
  assert_paddr_R9: assert property (@(posedge clk) disable iff (rst)
    done && found |-> (paddr[PAGE_SH-1:0] == ea_q[PAGE_SH-1:0]));
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] MASK = 32'h0000_03C0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] vsid = '0;
  logic [31:0] ea = '0;
  logic        store = 1'b0;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        done, found, wr_ok;
  logic [31:0] paddr;

  int checks = 0;
  int fails = 0;

  hpt_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .vsid(vsid), .ea(ea), .store(store),
    .tbl_base(BASE), .tbl_mask(MASK),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
    .done(done), .found(found), .paddr(paddr), .wr_ok(wr_ok)
  );

  always #(CLK_P/2) clk = ~clk;

  // memory image and access log
  logic [31:0] mem [0:255];
  logic [31:0] rlog [0:63];
  logic [31:0] wlog_a [0:7];
  logic [7:0]  wlog_d [0:7];
  int rcnt = 0;
  int wcnt = 0;
  logic [1:0] gate = '0;

  function automatic logic [7:0] widx(input logic [31:0] a);
    logic [31:0] d;
    d = (a - BASE) >> 2;
    return d[7:0];
  endfunction

  always @(negedge clk) begin
    gate = gate + 1'b1;
    mem_rd_ready = 1'b0;
    mem_wr_ready = 1'b0;
    if (mem_rd_valid && gate != 2'b01) begin
      mem_rd_ready = 1'b1;
      mem_rd_data  = mem[widx(mem_rd_addr)];
      if (rcnt < 64) rlog[rcnt] = mem_rd_addr;
      rcnt++;
    end else if (mem_wr_valid && gate != 2'b10) begin
      mem_wr_ready = 1'b1;
      mem[widx(mem_wr_addr)][31 - 8*mem_wr_addr[1:0] -: 8] = mem_wr_data;
      if (wcnt < 8) begin
        wlog_a[wcnt] = mem_wr_addr;
        wlog_d[wcnt] = mem_wr_data;
      end
      wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rcnt = 0;
    wcnt = 0;
  endtask

  task automatic launch(input logic [23:0] v, input logic [31:0] e, input logic s);
    @(negedge clk);
    vsid = v; ea = e; store = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  // one hit lookup: entry in slot k of pass p, r/c bits, store flag
  task automatic hit_case(input int iter, input int k, input int p,
                          input bit rb, input bit cb, input bit s, input bit busy_start);
    logic [23:0] v;
    logic [15:0] pidx;
    logic [31:0] e, g, entry, w0, w1, w1_new, exp_pa;
    logic [23:0] hash;
    bit ok;
    int exp_rd, exp_wr, wi;
    v    = 24'h0A5A00 ^ 24'(iter * 24'h1357);
    pidx = 16'hC3A0 + 16'(iter * 16'h0421);
    e    = {4'h7, pidx, 12'(iter * 37 + 5)};
    hash = v ^ {8'h00, pidx};
    g    = (p == 0) ? BASE + (({8'h00, hash} << 6) & MASK)
                    : BASE + ((~{8'h00, hash} << 6) & MASK);
    entry = g + 32'(k * 8);
    w0   = {1'b1, v, 1'(p), pidx[15:10]};
    w1   = {20'hA0000 ^ 20'(iter * 331), 3'b101, rb, cb, 5'b01010, 2'b10};
    clear_mem();
    mem[widx(entry)]     = w0;
    mem[widx(entry) + 1] = w1;
    // decoy 1: matching tag but wrong H in primary group (R2)
    if (p == 1) mem[widx(BASE + (({8'h00, hash} << 6) & MASK) + 32'(k * 8))] = {1'b1, v, 1'b1, pidx[15:10]};
    // decoy 2: matching tag, invalid, earlier slot (R2)
    if (k > 0) mem[widx(entry - 8)] = {1'b0, v, 1'(p), pidx[15:10]};
    launch(v, e, s);
    if (busy_start) begin
      repeat (3) @(negedge clk);
      vsid = ~v; ea = ~e; store = ~s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R10", "done seen", 32'(ok), 32'd1);
    exp_rd = p * 8 + k + 2;
    exp_wr = (!rb ? 1 : 0) + ((!cb && s) ? 1 : 0);
    exp_pa = {w1[31:12], e[11:0]};
    chk(found == 1'b1, "R2", "found", 32'(found), 32'd1);
    chk(paddr == exp_pa, "R9", "paddr", paddr, exp_pa);
    chk(wr_ok == (cb || s), "R8", "wr_ok", 32'(wr_ok), 32'(cb || s));
    chk(rcnt == exp_rd, p ? "R4" : "R3", "read count", 32'(rcnt), 32'(exp_rd));
    chk(rlog[0] == BASE + (({8'h00, hash} << 6) & MASK), "R1", "first read", rlog[0],
        BASE + (({8'h00, hash} << 6) & MASK));
    if (p == 1)
      chk(rlog[8] == g, "R4", "secondary first read", rlog[8], g);
    chk(rlog[exp_rd - 2] == entry, "R3", "word0 read", rlog[exp_rd - 2], entry);
    chk(rlog[exp_rd - 1] == entry + 4, "R3", "word1 read", rlog[exp_rd - 1], entry + 4);
    chk(wcnt == exp_wr, "R6", "write count", 32'(wcnt), 32'(exp_wr));
    wi = 0;
    if (!rb) begin
      chk(wlog_a[wi] == entry + 6 && wlog_d[wi] == (w1[15:8] | 8'h01), "R6", "R byte",
          {wlog_a[wi][23:0], wlog_d[wi]}, {(entry[23:0] + 24'd6), w1[15:8] | 8'h01});
      wi++;
    end
    if (!cb && s)
      chk(wlog_a[wi] == entry + 7 && wlog_d[wi] == (w1[7:0] | 8'h80), "R7", "C byte",
          {wlog_a[wi][23:0], wlog_d[wi]}, {(entry[23:0] + 24'd7), w1[7:0] | 8'h80});
    w1_new = w1 | 32'h100 | ((!cb && s) ? 32'h80 : 32'h0);
    chk(mem[widx(entry) + 1] == w1_new, "R7", "entry word 1 after walk",
        mem[widx(entry) + 1], w1_new);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done pulse width", 32'(done), 32'd0);
  endtask

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(done == 0 && found == 0 && wr_ok == 0, "R12", "reset outputs",
        {29'b0, done, found, wr_ok}, 32'd0);
    chk(!mem_rd_valid && !mem_wr_valid, "R12", "reset ports",
        {30'b0, mem_rd_valid, mem_wr_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_rd_valid && !done, "R12", "idle after reset",
        {30'b0, mem_rd_valid, done}, 32'd0);

    // miss: empty table, both passes scanned (R5)
    clear_mem();
    launch(24'h123456, 32'h2345_6789, 1'b1);
    wait_done(ok);
    chk(ok && found == 1'b0, "R5", "miss found", 32'(found), 32'd0);
    chk(wr_ok == 1'b0, "R5", "miss wr_ok", 32'(wr_ok), 32'd0);
    chk(rcnt == 16, "R5", "miss reads", 32'(rcnt), 32'd16);
    chk(wcnt == 0, "R5", "miss writes", 32'(wcnt), 32'd0);

    // sweep: slot x pass x R x C x store
    for (int it = 0; it < 128; it++)
      hit_case(it, it % 8, (it / 8) % 2, it[4], it[5], it[6], 1'b0);

    // start pulses during a walk are ignored (R10)
    hit_case(200, 5, 1, 1'b0, 1'b0, 1'b1, 1'b1);
    hit_case(201, 2, 0, 1'b1, 1'b0, 1'b0, 1'b1);

    summary();
  end
endmodule